// File: doc/BRIEF.md
# Programmable-Format Asynchronous Serial Transmitter

This block turns characters queued in a sixteen-entry buffer into an asynchronous serial stream. Every frame has a space start bit, then five to eight data bits sent least significant first, then an optional parity bit, then a mark stop period. The stop period can be set in sixteenths of a bit time, from one bit to just under two. Parity can be computed as odd or even, held at a fixed level, or left out.

The bit timing comes from one of two sources. One is a one-cycle enable pulse at sixteen times the bit rate. The other is an external clock at the bit rate, which moves data on its falling edge. The host fills the buffer through a simple write strobe and reads the buffer status and an interrupt at one of four fill thresholds. A clear-to-send input can hold back new characters. A break command holds the line at space until a stop command arrives, and then sends a full bit time of mark. In local loopback the serial line stays at mark and the stream appears only on an internal output.

Top module: `async_tx_fmt`

## Requirements
- R1: A frame is one space (0) start bit, then data bits least significant first, then the stop period at mark (1). The number of data bits is 5 + `char_len` (codes 0 to 3 give 5 to 8 bits).
- R2: When `par_mode` is 00, a parity bit follows the data. With `par_odd` = 0 it makes the count of ones even, and with `par_odd` = 1 it makes the count odd. When `par_mode` is 10 or 11, no parity bit is sent.
- R3: When `par_mode` is 01, the parity bit is sent at the level opposite to `par_odd`.
- R4: In 16x mode every start, data and parity bit lasts 16 `tick16` pulses, and the stop period lasts 16 + `stop_code` pulses. A character waiting in the buffer starts right at the end of the previous stop period, with no idle gap.
- R5: When `use_ext1x` is 1, each bit advances on one falling edge of `ext_clk1x` and `tick16` is ignored. The stop period is one bit for `stop_code` 0 to 7 and two bits for 8 to 15.
- R6: The buffer holds 16 characters and sends them in write order. A write made while it holds 16 is dropped, even in the cycle a character is taken out. `fifo_count`, `fifo_full` and `fifo_empty` report the fill level.
- R7: `tx_irq` is high when `tx_enable` is 1 and the number of free slots is at least the threshold picked by `irq_level`: 0 selects 16, 1 selects 8, 2 selects 4 and 3 selects 1.
- R8: While `tx_enable` is 0, no character is taken from the buffer, and an idle line stays at mark.
- R9: While `cts_gate` is 1 and `cts_n` is 1, no new character starts. Once `cts_n` goes low, the next character starts on the next bit-rate step.
- R10: While `local_loop` is 1, `txd` stays at mark and the frames appear on `ser_int`.
- R11: A `brk_start` pulse drives the line to space once any character in flight has finished. The line stays at space until a `brk_stop` pulse, and then stays at mark for at least one bit time before the next character starts.
- R12: After reset `txd` is 1, the buffer is empty with a count of 0, `tx_idle` is 1, and `tx_irq` is 0 while `tx_enable` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Character to queue |
| tick16 | input | 1 | Enable pulse at sixteen times the bit rate |
| ext_clk1x | input | 1 | External bit-rate clock; data moves on its falling edge |
| use_ext1x | input | 1 | 1 selects the external bit-rate clock |
| tx_enable | input | 1 | Allows characters to be taken from the buffer |
| local_loop | input | 1 | Holds `txd` at mark; stream only on `ser_int` |
| cts_gate | input | 1 | Makes `cts_n` gate the start of new characters |
| cts_n | input | 1 | Active-low clear-to-send |
| char_len | input | 2 | Data bits minus five |
| par_mode | input | 2 | 00 computed, 01 fixed level, 1x none |
| par_odd | input | 1 | Odd select (computed) or inverted level (fixed) |
| stop_code | input | 4 | Stop period extension in sixteenths of a bit |
| brk_start | input | 1 | Pulse: begin line break |
| brk_stop | input | 1 | Pulse: end line break |
| irq_level | input | 2 | Interrupt threshold select |
| txd | output | 1 | Serial line, mark high |
| ser_int | output | 1 | Serial stream before the loopback gate |
| fifo_count | output | 5 | Characters in the buffer |
| fifo_full | output | 1 | Buffer holds 16 characters |
| fifo_empty | output | 1 | Buffer holds no characters |
| tx_idle | output | 1 | Buffer empty and no frame or break in progress |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The buffer write and the removal of a character by the serializer can happen on the same clock edge, and when the buffer is full that edge decides whether the write is dropped. The bench fills the buffer with clear-to-send held off. It then waits for the cycle just before a bit-rate tick and, in that one cycle, lowers `cts_n` and writes one more character. It judges the result by the count dropping to 15 with the start bit already on the line, and by the sixteen frames that follow carrying the original characters with no trace of the late write.

// File: rtl/atx_pkg.sv
package atx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_BRK,
      ST_BRKEND
   } tx_state_e;

   typedef enum logic [1:0] {
      PM_CALC  = 2'b00,
      PM_FIXED = 2'b01,
      PM_OFF   = 2'b10,
      PM_OFF2  = 2'b11
   } par_mode_e;

   // a parity bit is present for the computed and fixed modes
   function automatic logic par_present(input logic [1:0] mode);
      return (mode == PM_CALC) || (mode == PM_FIXED);
   endfunction

   // parity bit over the active data bits only
   function automatic logic par_value(input logic [7:0] data,
                                      input logic [1:0] len,
                                      input logic [1:0] mode,
                                      input logic       odd);
      logic [7:0] act;
      logic       x;
      act = data & (8'hFF >> (2'd3 - len));
      x   = ^act;
      if (mode == PM_FIXED) return ~odd;
      if (mode == PM_CALC)  return odd ? ~x : x;
      return 1'b0;
   endfunction

endpackage

// File: rtl/atx_fifo.sv
module atx_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr,
   input  logic [W-1:0]               wdata,
   input  logic                       rd,
   output logic [W-1:0]               rdata,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full,
   output logic                       empty
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("atx_fifo: DEPTH must be a power of two of at least 4");
   end
   if (W < 1) begin : g_bad_width
      $error("atx_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = wr && !full;
   assign do_pop  = rd && !empty;
   assign rdata   = mem[rp_q];
   assign count   = cnt_q;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + PW'(1);
         if (do_pop)  rp_q <= rp_q + PW'(1);
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // a write into a full buffer without a read must leave the count alone
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr && !rd) |=> $stable(cnt_q));

   always_comb begin
      if (rst_n) assert_count_bound_R6: assert (cnt_q <= CW'(DEPTH));
   end

endmodule

// File: rtl/atx_pace.sv
module atx_pace #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick16,
   input  logic ext_clk,
   input  logic ext_mode,
   output logic step
);
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("atx_pace: SYNC_STAGES must lie in 0..4");
   end

   logic synced, prev_q, fall;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign synced = ext_clk;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else begin
            chain_q[0] <= ext_clk;
            for (int i = 1; i < SYNC_STAGES; i++) chain_q[i] <= chain_q[i-1];
         end
      end
      assign synced = chain_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= synced;
   end

   assign fall = prev_q && !synced;
   assign step = ext_mode ? fall : tick16;

   // in 1x mode steps come from edges, so two never stand back to back
   assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_mode && step) |=> (!step || !ext_mode));

endmodule

// File: rtl/atx_irq.sv
module atx_irq #(
   parameter int DEPTH = 16
) (
   input  logic                       en,
   input  logic [1:0]                 level,
   input  logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       irq
);
   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 4) begin : g_bad_depth
      $error("atx_irq: DEPTH must be at least 4");
   end

   logic [CW-1:0] thr [4];
   logic [CW-1:0] free;

   for (genvar g = 0; g < 4; g++) begin : g_thr
      if (g == 3) begin : g_one
         assign thr[g] = CW'(1);
      end else begin : g_frac
         assign thr[g] = CW'(DEPTH >> g);
      end
   end

   assign free = CW'(DEPTH) - count;
   assign irq  = en && (free >= thr[level]);

endmodule

// File: rtl/atx_shifter.sv
module atx_shifter
   import atx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       ext_mode,
   input  logic       tx_en,
   input  logic       cts_ok,
   input  logic [1:0] char_len,
   input  logic [1:0] par_mode,
   input  logic       par_odd,
   input  logic [3:0] stop_code,
   input  logic       brk_start,
   input  logic       brk_stop,
   input  logic       buf_empty,
   input  logic [7:0] buf_data,
   output logic       pop,
   output logic       ser,
   output logic       busy
);
   localparam int CNTW = $clog2(OVS + 16);

   if (OVS < 2) begin : g_bad_ovs
      $error("atx_shifter: OVS must be at least 2");
   end

   tx_state_e       st_q, st_d;
   logic [CNTW-1:0] cnt_q, cnt_d, need;
   logic [7:0]      sh_q, sh_d;
   logic [2:0]      idx_q, idx_d;
   logic            par_q, par_d;
   logic            brk_q, brk_d;
   logic [3:0]      nbits;
   logic            last, go;

   assign nbits = 4'd5 + {2'b00, char_len};
   assign go    = tx_en && cts_ok && !buf_empty && !brk_q;

   always_comb begin
      if (st_q == ST_STOP) begin
         if (ext_mode) need = stop_code[3] ? CNTW'(2) : CNTW'(1);
         else          need = CNTW'(OVS) + CNTW'(stop_code);
      end else begin
         need = ext_mode ? CNTW'(1) : CNTW'(OVS);
      end
   end

   assign last = step && (cnt_q == need - CNTW'(1));

   always_comb begin
      st_d  = st_q;
      sh_d  = sh_q;
      idx_d = idx_q;
      par_d = par_q;
      pop   = 1'b0;
      brk_d = (brk_q || brk_start) && !brk_stop;
      cnt_d = cnt_q;
      if (step && st_q != ST_IDLE && st_q != ST_BRK)
         cnt_d = last ? '0 : cnt_q + CNTW'(1);

      unique case (st_q)
         ST_IDLE: begin
            if (brk_q) st_d = ST_BRK;
            else if (go && step) begin
               pop   = 1'b1;
               sh_d  = buf_data;
               par_d = par_value(buf_data, char_len, par_mode, par_odd);
               st_d  = ST_START;
               cnt_d = '0;
            end
         end
         ST_START: begin
            if (last) begin
               st_d  = ST_DATA;
               idx_d = '0;
            end
         end
         ST_DATA: begin
            if (last) begin
               sh_d = {1'b0, sh_q[7:1]};
               if ({1'b0, idx_q} == nbits - 4'd1)
                  st_d = par_present(par_mode) ? ST_PAR : ST_STOP;
               else
                  idx_d = idx_q + 3'd1;
            end
         end
         ST_PAR: begin
            if (last) st_d = ST_STOP;
         end
         ST_STOP, ST_BRKEND: begin
            if (last) begin
               if (brk_q) st_d = ST_BRK;
               else if (go) begin
                  pop   = 1'b1;
                  sh_d  = buf_data;
                  par_d = par_value(buf_data, char_len, par_mode, par_odd);
                  st_d  = ST_START;
               end else st_d = ST_IDLE;
            end
         end
         ST_BRK: begin
            if (brk_stop) begin
               st_d  = ST_BRKEND;
               cnt_d = '0;
            end
         end
         default: st_d = ST_IDLE;
      endcase

      if (st_q != ST_BRK && st_d == ST_BRK) brk_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         sh_q  <= '0;
         idx_q <= '0;
         par_q <= 1'b0;
         brk_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         sh_q  <= sh_d;
         idx_q <= idx_d;
         par_q <= par_d;
         brk_q <= brk_d;
      end
   end

   always_comb begin
      unique case (st_q)
         ST_START, ST_BRK: ser = 1'b0;
         ST_DATA:          ser = sh_q[0];
         ST_PAR:           ser = par_q;
         default:          ser = 1'b1;
      endcase
   end

   assign busy = (st_q != ST_IDLE);

   assert_pop_has_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !buf_empty);

   assert_pop_on_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> step);

   assert_start_space_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> !ser);

   assert_no_pop_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> !pop);

   assert_cts_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cts_ok |-> !pop);

endmodule

// File: rtl/async_tx_fmt.sv
module async_tx_fmt #(
   parameter int DEPTH       = 16,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [7:0]                 wr_data,
   input  logic                       tick16,
   input  logic                       ext_clk1x,
   input  logic                       use_ext1x,
   input  logic                       tx_enable,
   input  logic                       local_loop,
   input  logic                       cts_gate,
   input  logic                       cts_n,
   input  logic [1:0]                 char_len,
   input  logic [1:0]                 par_mode,
   input  logic                       par_odd,
   input  logic [3:0]                 stop_code,
   input  logic                       brk_start,
   input  logic                       brk_stop,
   input  logic [1:0]                 irq_level,
   output logic                       txd,
   output logic                       ser_int,
   output logic [$clog2(DEPTH+1)-1:0] fifo_count,
   output logic                       fifo_full,
   output logic                       fifo_empty,
   output logic                       tx_idle,
   output logic                       tx_irq
);
   logic       step, pop, ser, busy, cts_ok;
   logic [7:0] head;

   assign cts_ok = !cts_gate || !cts_n;

   atx_fifo #(.W(8), .DEPTH(DEPTH)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_en),
      .wdata (wr_data),
      .rd    (pop),
      .rdata (head),
      .count (fifo_count),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   atx_pace #(.SYNC_STAGES(SYNC_STAGES)) u_pace (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick16   (tick16),
      .ext_clk  (ext_clk1x),
      .ext_mode (use_ext1x),
      .step     (step)
   );

   atx_shifter #(.OVS(OVS)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .ext_mode  (use_ext1x),
      .tx_en     (tx_enable),
      .cts_ok    (cts_ok),
      .char_len  (char_len),
      .par_mode  (par_mode),
      .par_odd   (par_odd),
      .stop_code (stop_code),
      .brk_start (brk_start),
      .brk_stop  (brk_stop),
      .buf_empty (fifo_empty),
      .buf_data  (head),
      .pop       (pop),
      .ser       (ser),
      .busy      (busy)
   );

   atx_irq #(.DEPTH(DEPTH)) u_irq (
      .en    (tx_enable),
      .level (irq_level),
      .count (fifo_count),
      .irq   (tx_irq)
   );

   assign ser_int = ser;
   assign txd     = local_loop ? 1'b1 : ser;
   assign tx_idle = !busy && fifo_empty;

   // the block's own line must not leave mark while loopback is on
   assert_loop_mark_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (local_loop && !ser) |-> txd);

endmodule

// File: tb/sim_async_tx_fmt.sv
`timescale 1ns/1ps
module sim_async_tx_fmt;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       tick16 = 1'b0;
   logic       ext_clk1x = 1'b1;
   logic       use_ext1x = 1'b0;
   logic       tx_enable = 1'b0;
   logic       local_loop = 1'b0;
   logic       cts_gate = 1'b0;
   logic       cts_n = 1'b1;
   logic [1:0] char_len = 2'd3;
   logic [1:0] par_mode = 2'b10;
   logic       par_odd = 1'b0;
   logic [3:0] stop_code = 4'd0;
   logic       brk_start = 1'b0;
   logic       brk_stop = 1'b0;
   logic [1:0] irq_level = 2'd0;
   logic       txd, ser_int, fifo_full, fifo_empty, tx_idle, tx_irq;
   logic [4:0] fifo_count;

   int  errs = 0;
   int  checks = 0;
   int  cyc = 0;
   bit  done = 1'b0;
   int  loop_low = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   async_tx_fmt u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .tick16(tick16), .ext_clk1x(ext_clk1x), .use_ext1x(use_ext1x),
      .tx_enable(tx_enable), .local_loop(local_loop), .cts_gate(cts_gate),
      .cts_n(cts_n), .char_len(char_len), .par_mode(par_mode),
      .par_odd(par_odd), .stop_code(stop_code), .brk_start(brk_start),
      .brk_stop(brk_stop), .irq_level(irq_level), .txd(txd),
      .ser_int(ser_int), .fifo_count(fifo_count), .fifo_full(fifo_full),
      .fifo_empty(fifo_empty), .tx_idle(tx_idle), .tx_irq(tx_irq)
   );

   // tick every 4 cycles (bit = 64 cycles); external 1x clock period 16 cycles
   initial begin
      int ph = 0;
      forever begin
         @(posedge clk);
         #1;
         ph++;
         tick16 = (ph % 4 == 0);
         if (ph % 8 == 0) ext_clk1x = ~ext_clk1x;
      end
   end

   typedef struct packed {
      logic [1:0] len;
      logic [1:0] pm;
      logic       odd;
      logic [3:0] stop;
      logic [7:0] data;
      logic       hp;
      logic       par;
      logic [8:0] ticks;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{2'd3, 2'b10, 1'b0, 4'd0,  8'hA5, 1'b0, 1'b0, 9'd160},
      '{2'd3, 2'b00, 1'b0, 4'd0,  8'hA5, 1'b1, 1'b0, 9'd176},
      '{2'd3, 2'b00, 1'b1, 4'd15, 8'h01, 1'b1, 1'b0, 9'd191},
      '{2'd2, 2'b00, 1'b0, 4'd8,  8'hFF, 1'b1, 1'b1, 9'd168},
      '{2'd0, 2'b10, 1'b0, 4'd0,  8'h3A, 1'b0, 1'b0, 9'd112},
      '{2'd1, 2'b01, 1'b0, 4'd4,  8'h00, 1'b1, 1'b1, 9'd148},
      '{2'd1, 2'b01, 1'b1, 4'd0,  8'h3F, 1'b1, 1'b0, 9'd144},
      '{2'd0, 2'b00, 1'b1, 4'd1,  8'h1F, 1'b1, 1'b0, 9'd129}
   };

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   task automatic push(input logic [7:0] d);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   function automatic logic line(input bit sel);
      return sel ? ser_int : txd;
   endfunction

   // waits for space at a negedge, then samples each bit in its middle
   task automatic rx_frame(input int bc, input int nb, input bit hp, input bit sel,
                           output logic [7:0] d, output logic p, output logic sb,
                           output logic st, output int t0);
      while (line(sel) !== 1'b0) @(negedge clk);
      t0 = cyc;
      repeat (bc / 2) @(negedge clk);
      sb = line(sel);
      if (sel && txd !== 1'b1) loop_low++;
      d = '0;
      for (int i = 0; i < nb; i++) begin
         repeat (bc) @(negedge clk);
         d[i] = line(sel);
         if (sel && txd !== 1'b1) loop_low++;
      end
      p = 1'b0;
      if (hp) begin
         repeat (bc) @(negedge clk);
         p = line(sel);
      end
      repeat (bc) @(negedge clk);
      st = line(sel);
   endtask

   task automatic wait_idle();
      while (tx_idle !== 1'b1) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errs++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic       p, sb, st;
      int         t0, t1, cs;

      // ---- reset state (R12)
      repeat (3) @(negedge clk);
      chk("R12", "txd in reset", txd, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R12", "txd", txd, 1);
      chk("R12", "count", fifo_count, 0);
      chk("R12", "empty", fifo_empty, 1);
      chk("R12", "idle", tx_idle, 1);
      chk("R12", "irq while disabled", tx_irq, 0);

      // ---- table of formats (R1..R4)
      tx_enable = 1'b1;
      foreach (VECS[k]) begin
         int nb;
         char_len  = VECS[k].len;
         par_mode  = VECS[k].pm;
         par_odd   = VECS[k].odd;
         stop_code = VECS[k].stop;
         nb = 5 + int'(VECS[k].len);
         @(negedge clk);
         push(VECS[k].data);
         push(8'h00);
         rx_frame(64, nb, VECS[k].hp, 1'b0, d, p, sb, st, t0);
         chk("R1", $sformatf("vec%0d start", k), sb, 0);
         chk("R1", $sformatf("vec%0d data", k), d, VECS[k].data & ((1 << nb) - 1));
         if (VECS[k].hp)
            chk(VECS[k].pm == 2'b01 ? "R3" : "R2", $sformatf("vec%0d parity", k), p, VECS[k].par);
         chk("R1", $sformatf("vec%0d stop", k), st, 1);
         rx_frame(64, nb, VECS[k].hp, 1'b0, d, p, sb, st, t1);
         chk("R4", $sformatf("vec%0d frame period", k), t1 - t0, 4 * int'(VECS[k].ticks));
         chk("R1", $sformatf("vec%0d follow data", k), d, 0);
         wait_idle();
      end

      // ---- external 1x clock (R5): 8 data bits, no parity
      char_len = 2'd3; par_mode = 2'b10; use_ext1x = 1'b1;
      stop_code = 4'd0;
      @(negedge clk);
      push(8'hC3); push(8'h5A);
      rx_frame(16, 8, 1'b0, 1'b0, d, p, sb, st, t0);
      chk("R5", "1x data", d, 8'hC3);
      rx_frame(16, 8, 1'b0, 1'b0, d, p, sb, st, t1);
      chk("R5", "1x one stop period", t1 - t0, 160);
      chk("R5", "1x second data", d, 8'h5A);
      wait_idle();
      stop_code = 4'd8;
      @(negedge clk);
      push(8'h96); push(8'h00);
      rx_frame(16, 8, 1'b0, 1'b0, d, p, sb, st, t0);
      chk("R5", "1x data b", d, 8'h96);
      rx_frame(16, 8, 1'b0, 1'b0, d, p, sb, st, t1);
      chk("R5", "1x two stop period", t1 - t0, 176);
      wait_idle();
      use_ext1x = 1'b0; stop_code = 4'd0;

      // ---- disabled transmitter (R8)
      tx_enable = 1'b0;
      @(negedge clk);
      push(8'h81); push(8'h7E);
      repeat (300) @(negedge clk);
      chk("R8", "count kept while disabled", fifo_count, 2);
      chk("R8", "line mark while disabled", txd, 1);
      tx_enable = 1'b1;
      rx_frame(64, 8, 1'b0, 1'b0, d, p, sb, st, t0);
      chk("R8", "first after enable", d, 8'h81);
      rx_frame(64, 8, 1'b0, 1'b0, d, p, sb, st, t0);
      chk("R8", "second after enable", d, 8'h7E);
      wait_idle();

      // ---- local loopback (R10)
      local_loop = 1'b1;
      loop_low = 0;
      @(negedge clk);
      push(8'h3C);
      rx_frame(64, 8, 1'b0, 1'b1, d, p, sb, st, t0);
      chk("R10", "internal stream data", d, 8'h3C);
      chk("R10", "txd low samples", loop_low, 0);
      wait_idle();
      local_loop = 1'b0;

      // ---- break (R11)
      brk_start = 1'b1;
      @(negedge clk);
      brk_start = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11", "space during break", txd, 0);
      push(8'h55);
      repeat (100) @(negedge clk);
      chk("R11", "space held", txd, 0);
      chk("R11", "char waits during break", fifo_count, 1);
      brk_stop = 1'b1;
      cs = cyc;
      @(negedge clk);
      brk_stop = 1'b0;
      @(negedge clk);
      chk("R11", "mark after stop", txd, 1);
      rx_frame(64, 8, 1'b0, 1'b0, d, p, sb, st, t0);
      chk("R11", "mark lasts a bit time", (t0 - cs >= 60) && (t0 - cs <= 68), 1);
      chk("R11", "char after break", d, 8'h55);
      wait_idle();

      // ---- interrupt levels, clear-to-send, overflow and same-edge write (R7 R9 R6)
      cts_gate = 1'b1; cts_n = 1'b1;
      for (int lv = 0; lv < 4; lv++) begin
         irq_level = 2'(lv);
         @(negedge clk);
         chk("R7", $sformatf("level %0d empty", lv), tx_irq, 1);
      end
      for (int i = 0; i < 8; i++) push(8'(i));
      irq_level = 2'd0; @(negedge clk);
      chk("R7", "level0 at 8", tx_irq, 0);
      irq_level = 2'd1; @(negedge clk);
      chk("R7", "level1 at 8", tx_irq, 1);
      for (int i = 8; i < 12; i++) push(8'(i));
      @(negedge clk);
      chk("R7", "level1 at 12", tx_irq, 0);
      irq_level = 2'd2; @(negedge clk);
      chk("R7", "level2 at 12", tx_irq, 1);
      for (int i = 12; i < 15; i++) push(8'(i));
      irq_level = 2'd3; @(negedge clk);
      chk("R7", "level3 at 15", tx_irq, 1);
      push(8'd15);
      chk("R7", "level3 at 16", tx_irq, 0);
      chk("R6", "full flag", fifo_full, 1);
      repeat (200) @(negedge clk);
      chk("R9", "no start while clear-to-send off", txd, 1);
      chk("R9", "count held", fifo_count, 16);
      push(8'hEE);
      chk("R6", "write into full dropped", fifo_count, 16);
      while (tick16 !== 1'b1) @(negedge clk);
      wr_en = 1'b1; wr_data = 8'hDD; cts_n = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R6", "same-edge write on full dropped", fifo_count, 15);
      chk("R9", "start on first step after release", txd, 0);
      for (int i = 0; i < 16; i++) begin
         rx_frame(64, 8, 1'b0, 1'b0, d, p, sb, st, t0);
         chk("R6", $sformatf("order entry %0d", i), d, i);
      end
      repeat (300) @(negedge clk);
      chk("R6", "no extra frame", tx_idle, 1);
      chk("R6", "empty after drain", fifo_count, 0);

      if (!done) begin
         done = 1'b1;
         summary();
         $finish;
      end
   end

endmodule